// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block gathers a wide bundle of level-sensitive interrupt inputs into groups of eight and drives one output line per group. A group line is high whenever at least one of its eight sources is both pending and enabled. Pending bits follow the input levels one clock behind. Enable bits change only through two write-only style operations, set and clear, so software never needs a read-modify-write to change one source.

A 32-bit register bus reaches the block through single-cycle read and write strobes, and read data is registered. The group space is split into 16-byte blocks. Each block serves four consecutive groups, one byte lane per group. Within a block, the four words are enable-set, enable-clear, raw pending status and masked status. Two summary words follow the group space and show which group lines are active. Writes that target a status or summary word are refused and raise a one-cycle error pulse. An elaboration option restricts the block to its lower groups, so that inputs of higher groups are never latched.

Top module: `comb_ctrl`

## Requirements
- R1: Input number n belongs to group n/8 and occupies bit n%8 of that group's pending byte.
- R2: Each pending bit takes the level its input had at the previous rising clock edge, so it goes high and comes back low with the input.
- R3: Output `grp_out[g]` is high exactly when group g has a bit that is set in both its enable mask and its pending byte.
- R4: A write to word index 0 of a block (address bits [3:2] = 0) ORs each byte lane j into the enable mask of group 4k+j, where k = address >> 4, and leaves enable bits that were already set unchanged.
- R5: A write to word index 1 clears, in the enable mask of the matching group, every bit that is set in byte lane j.
- R6: Block k at byte offset 16k serves groups 4k to 4k+3. Byte lane j is bits [8j+7:8j] and belongs to group 4k+j, for every word of the block.
- R7: A read of word index 2 returns the raw pending bytes, and a read of word index 3 returns pending ANDed with enable, each packed per byte lane.
- R8: The word at offset 0x100 reports group outputs 0 to 31 at bit position g, and the word at 0x104 reports groups 32 to 63 at bit position g-32.
- R9: A write to word index 2 or 3, or to any address at or above 0x100, changes no mask and no stored word and sets `bus_err` high for the one cycle after the write strobe. Legal writes leave `bus_err` low.
- R10: A read of word index 0 or 1 returns the last value written to that address.
- R11: Reset clears every mask, pending bit, output, read data and error flag. Every stored word is cleared as well, except those at 0xC0, 0xC4, 0xD0 and 0xD4, which become 0x01010101.
- R12: When EXTERNAL is set, inputs of groups at or above EXT_GROUP_LIMIT are ignored: their raw status reads zero and their outputs stay low.
- R13: Read data is updated one cycle after a read strobe. Its value reflects the state just before that edge, and it holds unchanged while no read strobe is present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_GROUPS*8 | Level-sensitive interrupt inputs, input n at bit n |
| grp_out | output | NUM_GROUPS | One combined line per group |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | ADDR_W | Byte address, bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse after a refused write |

## Verification
The assertions assume that inputs change only between clock edges and that no address targets a block beyond the configured group count, apart from the two summary words. They also assume that a read and a write strobe never fall in the same cycle on the same address. The stimulus drives every input on the falling edge and issues strobes for one cycle at a time. It uses only word-aligned addresses inside the group space, the summary pair and the refused status words. The bench also runs a second instance in restricted mode on the same bus, so both modes see identical traffic.

// File: rtl/comb_pkg.sv
package comb_pkg;

    localparam int SRC_PER_GRP = 8;
    localparam int GRP_PER_BLK = 4;
    localparam int BLK_BYTES   = 16;
    localparam int SUM_WORDS   = 2;
    localparam int SUM_W       = 32 * SUM_WORDS;

    // Stored words of these two blocks come out of reset preset
    localparam int          PRESET_BLK_LO = 12;
    localparam int          PRESET_BLK_HI = 13;
    localparam logic [31:0] PRESET_WORD   = 32'h0101_0101;

    typedef enum logic [1:0] {
        IDX_EN_SET = 2'd0,
        IDX_EN_CLR = 2'd1,
        IDX_RAW    = 2'd2,
        IDX_MASKED = 2'd3
    } reg_idx_e;

    typedef struct packed {
        logic     grp_hit;
        logic     sum_hit;
        logic     sum_sel;
        logic [7:0] blk;
        reg_idx_e idx;
    } bus_dec_t;

    function automatic bus_dec_t decode_addr(input logic [15:0] addr, input int num_blocks);
        bus_dec_t d;
        d.blk     = addr[11:4];
        d.idx     = reg_idx_e'(addr[3:2]);
        d.grp_hit = int'(addr[15:4]) < num_blocks;
        d.sum_hit = (int'(addr) >= num_blocks * BLK_BYTES) &&
                    (int'(addr) <  num_blocks * BLK_BYTES + 4 * SUM_WORDS);
        d.sum_sel = addr[2];
        return d;
    endfunction

    function automatic logic [31:0] stored_reset(input int blk);
        return (blk == PRESET_BLK_LO || blk == PRESET_BLK_HI) ? PRESET_WORD : 32'h0;
    endfunction

endpackage

// File: rtl/comb_src_latch.sv
module comb_src_latch
    import comb_pkg::*;
#(
    parameter int NUM_GROUPS      = 64,
    parameter bit EXTERNAL        = 1'b0,
    parameter int EXT_GROUP_LIMIT = 16
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [NUM_GROUPS*SRC_PER_GRP-1:0]      irq_in,
    output logic [NUM_GROUPS-1:0][SRC_PER_GRP-1:0] pend_q
);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        if (EXTERNAL && g >= EXT_GROUP_LIMIT) begin : g_blocked
            assign pend_q[g] = '0;
        end else begin : g_live
            logic [SRC_PER_GRP-1:0] lvl_q;

            always_ff @(posedge clk) begin
                if (rst) lvl_q <= '0;
                else     lvl_q <= irq_in[g*SRC_PER_GRP +: SRC_PER_GRP];
            end

            assign pend_q[g] = lvl_q;

            // R2
            r2_level_track_chk: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> pend_q[g] == $past(irq_in[g*SRC_PER_GRP +: SRC_PER_GRP]));
        end
    end

endmodule

// File: rtl/comb_mask_bank.sv
module comb_mask_bank
    import comb_pkg::*;
#(
    parameter  int NUM_GROUPS = 64,
    parameter  int ADDR_W     = 9,
    localparam int NUM_BLOCKS = NUM_GROUPS / GRP_PER_BLK,
    localparam int BLK_W      = $clog2(NUM_BLOCKS)
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   bus_wr,
    input  logic [ADDR_W-1:0]                      bus_addr,
    input  logic [31:0]                            bus_wdata,
    output logic [NUM_GROUPS-1:0][SRC_PER_GRP-1:0] mask_q,
    output logic [NUM_BLOCKS-1:0][1:0][31:0]       store_q,
    output logic                                   bus_err
);

    bus_dec_t         dec;
    logic             wr_ok;
    logic [BLK_W-1:0] blk_idx;
    logic             sel_lo;

    assign dec     = decode_addr(16'(bus_addr), NUM_BLOCKS);
    assign blk_idx = dec.blk[BLK_W-1:0];
    assign sel_lo  = dec.idx[0];
    assign wr_ok   = bus_wr && dec.grp_hit && !dec.sum_hit &&
                     (dec.idx == IDX_EN_SET || dec.idx == IDX_EN_CLR);

    // Enable masks: one byte per group, written through set / clear words
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_mask
        localparam int BK = g / GRP_PER_BLK;
        localparam int LN = g % GRP_PER_BLK;
        logic [SRC_PER_GRP-1:0] m_q;
        logic [SRC_PER_GRP-1:0] lane_w;
        logic                   hit;

        assign lane_w = bus_wdata[LN*SRC_PER_GRP +: SRC_PER_GRP];
        assign hit    = wr_ok && (blk_idx == BLK_W'(BK));

        always_ff @(posedge clk) begin
            if (rst) begin
                m_q <= '0;
            end else if (hit) begin
                if (dec.idx == IDX_EN_SET) m_q <= m_q | lane_w;
                else                       m_q <= m_q & ~lane_w;
            end
        end

        assign mask_q[g] = m_q;
    end

    // Readback copies of the set / clear words
    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_store
        for (genvar i = 0; i < 2; i++) begin : g_word
            logic [31:0] w_q;

            always_ff @(posedge clk) begin
                if (rst)
                    w_q <= stored_reset(b);
                else if (wr_ok && blk_idx == BLK_W'(b) && sel_lo == i[0])
                    w_q <= bus_wdata;
            end

            assign store_q[b][i] = w_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bus_err <= 1'b0;
        else     bus_err <= bus_wr && !wr_ok;
    end

    logic [NUM_BLOCKS-1:0][31:0] mask_blk;
    assign mask_blk = mask_q;

    // R4
    r4_set_or_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && dec.idx == IDX_EN_SET) |=>
        ((mask_blk[$past(blk_idx)] & $past(bus_wdata)) == $past(bus_wdata)) &&
        ((mask_blk[$past(blk_idx)] & $past(mask_blk[blk_idx])) == $past(mask_blk[blk_idx])));

    // R5
    r5_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && dec.idx == IDX_EN_CLR) |=>
        ((mask_blk[$past(blk_idx)] & $past(bus_wdata)) == 32'h0));

    // R9
    r9_refused_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !wr_ok) |=> bus_err && $stable(mask_q) && $stable(store_q));

    // R10
    r10_store_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ok |=> store_q[$past(blk_idx)][$past(sel_lo)] == $past(bus_wdata));

    // R11
    r11_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_q == '0) && !bus_err);

endmodule

// File: rtl/comb_read_mux.sv
module comb_read_mux
    import comb_pkg::*;
#(
    parameter  int NUM_GROUPS = 64,
    parameter  int ADDR_W     = 9,
    localparam int NUM_BLOCKS = NUM_GROUPS / GRP_PER_BLK,
    localparam int BLK_W      = $clog2(NUM_BLOCKS)
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   bus_rd,
    input  logic [ADDR_W-1:0]                      bus_addr,
    input  logic [NUM_GROUPS-1:0][SRC_PER_GRP-1:0] mask_q,
    input  logic [NUM_GROUPS-1:0][SRC_PER_GRP-1:0] pend_q,
    input  logic [NUM_BLOCKS-1:0][1:0][31:0]       store_q,
    input  logic [NUM_GROUPS-1:0]                  grp_out,
    output logic [31:0]                            bus_rdata
);

    bus_dec_t                    dec;
    logic [BLK_W-1:0]            blk_idx;
    logic [NUM_BLOCKS-1:0][31:0] mask_blk;
    logic [NUM_BLOCKS-1:0][31:0] pend_blk;
    logic [SUM_W-1:0]            sum_vec;
    logic [31:0]                 rd_next;

    assign dec      = decode_addr(16'(bus_addr), NUM_BLOCKS);
    assign blk_idx  = dec.blk[BLK_W-1:0];
    assign mask_blk = mask_q;
    assign pend_blk = pend_q;
    assign sum_vec  = SUM_W'(grp_out);

    always_comb begin
        rd_next = 32'h0;
        if (dec.grp_hit) begin
            unique case (dec.idx)
                IDX_EN_SET: rd_next = store_q[blk_idx][0];
                IDX_EN_CLR: rd_next = store_q[blk_idx][1];
                IDX_RAW:    rd_next = pend_blk[blk_idx];
                IDX_MASKED: rd_next = pend_blk[blk_idx] & mask_blk[blk_idx];
                default:    rd_next = 32'h0;
            endcase
        end else if (dec.sum_hit) begin
            rd_next = dec.sum_sel ? sum_vec[63:32] : sum_vec[31:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= 32'h0;
        else if (bus_rd) bus_rdata <= rd_next;
    end

    // R13
    r13_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    // R7
    r7_raw_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && dec.grp_hit && dec.idx == IDX_RAW) |=>
        bus_rdata == $past(pend_blk[blk_idx]));

    // R8
    r8_summary_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !dec.grp_hit && dec.sum_hit) |=>
        bus_rdata == ($past(dec.sum_sel) ? $past(sum_vec[63:32]) : $past(sum_vec[31:0])));

endmodule

// File: rtl/comb_ctrl.sv
module comb_ctrl
    import comb_pkg::*;
#(
    parameter int NUM_GROUPS      = 64,
    parameter bit EXTERNAL        = 1'b0,
    parameter int EXT_GROUP_LIMIT = 16,
    parameter int ADDR_W          = $clog2(NUM_GROUPS * 4 + SUM_WORDS * 4)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_GROUPS*SRC_PER_GRP-1:0] irq_in,
    output logic [NUM_GROUPS-1:0]             grp_out,
    input  logic                              bus_wr,
    input  logic                              bus_rd,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [31:0]                       bus_wdata,
    output logic [31:0]                       bus_rdata,
    output logic                              bus_err
);

    localparam int NUM_BLOCKS = NUM_GROUPS / GRP_PER_BLK;

    logic [NUM_GROUPS-1:0][SRC_PER_GRP-1:0] pend_q;
    logic [NUM_GROUPS-1:0][SRC_PER_GRP-1:0] mask_q;
    logic [NUM_BLOCKS-1:0][1:0][31:0]       store_q;

    comb_src_latch #(
        .NUM_GROUPS      (NUM_GROUPS),
        .EXTERNAL        (EXTERNAL),
        .EXT_GROUP_LIMIT (EXT_GROUP_LIMIT)
    ) u_latch (
        .clk    (clk),
        .rst    (rst),
        .irq_in (irq_in),
        .pend_q (pend_q)
    );

    comb_mask_bank #(
        .NUM_GROUPS (NUM_GROUPS),
        .ADDR_W     (ADDR_W)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .mask_q    (mask_q),
        .store_q   (store_q),
        .bus_err   (bus_err)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_out
        assign grp_out[g] = |(mask_q[g] & pend_q[g]);
    end

    comb_read_mux #(
        .NUM_GROUPS (NUM_GROUPS),
        .ADDR_W     (ADDR_W)
    ) u_rmux (
        .clk       (clk),
        .rst       (rst),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .mask_q    (mask_q),
        .pend_q    (pend_q),
        .store_q   (store_q),
        .grp_out   (grp_out),
        .bus_rdata (bus_rdata)
    );

    // R3
    r3_out_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((mask_q & pend_q) == '0) |-> (grp_out == '0));

    // R3
    r3_out_active_chk: assert property (@(posedge clk) disable iff (rst)
        (grp_out != '0) |-> ((mask_q & pend_q) != '0));

    if (EXTERNAL && EXT_GROUP_LIMIT < NUM_GROUPS) begin : g_ext_chk
        // R12
        r12_upper_silent_chk: assert property (@(posedge clk) disable iff (rst)
            grp_out[NUM_GROUPS-1:EXT_GROUP_LIMIT] == '0);
    end

endmodule

// File: tb/comb_ctrl_test.sv
module comb_ctrl_test;

    localparam int NG = 64;
    localparam int AW = 9;

    localparam logic [1:0] OP_W = 2'd0;
    localparam logic [1:0] OP_R = 2'd1;
    localparam logic [1:0] OP_I = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [8:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [23:0] tag;
    } vec_t;

    localparam int NV = 38;
    localparam vec_t VECS [NV] = '{
        '{OP_I, 9'd0,    32'd1,         32'd0,         "R1 "},
        '{OP_R, 9'h008,  32'd0,         32'h0000_0001, "R1 "},
        '{OP_R, 9'h00C,  32'd0,         32'h0000_0000, "R7 "},
        '{OP_I, 9'd13,   32'd1,         32'd0,         "R1 "},
        '{OP_R, 9'h008,  32'd0,         32'h0000_2001, "R1 "},
        '{OP_I, 9'd130,  32'd1,         32'd0,         "R6 "},
        '{OP_R, 9'h048,  32'd0,         32'h0000_0004, "R6 "},
        '{OP_I, 9'd511,  32'd1,         32'd0,         "R6 "},
        '{OP_R, 9'h0F8,  32'd0,         32'h8000_0000, "R6 "},
        '{OP_W, 9'h000,  32'h0000_00FF, 32'd0,         "R9 "},
        '{OP_R, 9'h00C,  32'd0,         32'h0000_0001, "R7 "},
        '{OP_R, 9'h000,  32'd0,         32'h0000_00FF, "R10"},
        '{OP_W, 9'h000,  32'h0000_2000, 32'd0,         "R9 "},
        '{OP_R, 9'h00C,  32'd0,         32'h0000_2001, "R4 "},
        '{OP_R, 9'h000,  32'd0,         32'h0000_2000, "R10"},
        '{OP_R, 9'h100,  32'd0,         32'h0000_0003, "R8 "},
        '{OP_R, 9'h104,  32'd0,         32'h0000_0000, "R8 "},
        '{OP_W, 9'h0F0,  32'hFF00_0000, 32'd0,         "R9 "},
        '{OP_R, 9'h104,  32'd0,         32'h8000_0000, "R8 "},
        '{OP_R, 9'h0FC,  32'd0,         32'h8000_0000, "R6 "},
        '{OP_W, 9'h004,  32'h0000_0001, 32'd0,         "R9 "},
        '{OP_R, 9'h00C,  32'd0,         32'h0000_2000, "R5 "},
        '{OP_R, 9'h100,  32'd0,         32'h0000_0002, "R5 "},
        '{OP_R, 9'h004,  32'd0,         32'h0000_0001, "R10"},
        '{OP_I, 9'd13,   32'd0,         32'd0,         "R2 "},
        '{OP_R, 9'h008,  32'd0,         32'h0000_0001, "R2 "},
        '{OP_R, 9'h100,  32'd0,         32'h0000_0000, "R3 "},
        '{OP_W, 9'h040,  32'h0000_00FF, 32'd0,         "R9 "},
        '{OP_R, 9'h100,  32'd0,         32'h0001_0000, "R8 "},
        '{OP_W, 9'h008,  32'hFFFF_FFFF, 32'd1,         "R9 "},
        '{OP_R, 9'h008,  32'd0,         32'h0000_0001, "R9 "},
        '{OP_W, 9'h00C,  32'hFFFF_FFFF, 32'd1,         "R9 "},
        '{OP_R, 9'h00C,  32'd0,         32'h0000_0000, "R9 "},
        '{OP_W, 9'h100,  32'hFFFF_FFFF, 32'd1,         "R9 "},
        '{OP_R, 9'h100,  32'd0,         32'h0001_0000, "R9 "},
        '{OP_W, 9'h104,  32'hFFFF_FFFF, 32'd1,         "R9 "},
        '{OP_R, 9'h104,  32'd0,         32'h8000_0000, "R9 "},
        '{OP_R, 9'h040,  32'd0,         32'h0000_00FF, "R10"}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NG*8-1:0] irq = '0;
    logic            wr = 1'b0;
    logic            rd = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [31:0]     wdata = '0;
    logic [NG-1:0]   out_a, out_b;
    logic [31:0]     rdata_a, rdata_b;
    logic            err_a, err_b;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    comb_ctrl #(.NUM_GROUPS(NG)) uut (
        .clk(clk), .rst(rst), .irq_in(irq), .grp_out(out_a),
        .bus_wr(wr), .bus_rd(rd), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata_a), .bus_err(err_a)
    );

    comb_ctrl #(.NUM_GROUPS(NG), .EXTERNAL(1'b1), .EXT_GROUP_LIMIT(16)) uut_ext (
        .clk(clk), .rst(rst), .irq_in(irq), .grp_out(out_b),
        .bus_wr(wr), .bus_rd(rd), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata_b), .bus_err(err_b)
    );

    task automatic check(input logic [23:0] tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a);
        @(negedge clk);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: reset state at the ports
        check("R11", {32'h0, rdata_a}, 64'h0);
        check("R11", {63'h0, err_a}, 64'h0);
        check("R11", out_a, 64'h0);
        bus_read(9'h0C0); check("R11", {32'h0, rdata_a}, 64'h0101_0101);
        bus_read(9'h0C4); check("R11", {32'h0, rdata_a}, 64'h0101_0101);
        bus_read(9'h0D0); check("R11", {32'h0, rdata_a}, 64'h0101_0101);
        bus_read(9'h0D4); check("R11", {32'h0, rdata_a}, 64'h0101_0101);
        bus_read(9'h000); check("R11", {32'h0, rdata_a}, 64'h0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            case (v.op)
                OP_W: begin
                    bus_write(v.addr, v.data);
                    check(v.tag, {63'h0, err_a}, {32'h0, v.exp});
                end
                OP_R: begin
                    bus_read(v.addr);
                    check(v.tag, {32'h0, rdata_a}, {32'h0, v.exp});
                end
                default: begin
                    @(negedge clk);
                    irq[v.addr] = v.data[0];
                    @(negedge clk);
                end
            endcase
        end

        // R3: live group lines (groups 16 and 63 active)
        check("R3 ", out_a, 64'h8000_0000_0001_0000);

        // R12: restricted instance ignores groups 16 and up
        bus_write(9'h000, 32'h0000_0001);
        check("R12", out_a, 64'h8000_0000_0001_0001);
        check("R12", out_b, 64'h0000_0000_0000_0001);
        bus_read(9'h048);
        check("R12", {32'h0, rdata_b}, 64'h0);
        check("R7 ", {32'h0, rdata_a}, 64'h0000_0004);

        // R13: read data holds while no read strobe arrives
        @(negedge clk); irq[130] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R13", {32'h0, rdata_a}, 64'h0000_0004);
        bus_read(9'h048);
        check("R2 ", {32'h0, rdata_a}, 64'h0);
        check("R3 ", out_a, 64'h8000_0000_0000_0001);

        // R11: reset in the middle of operation
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        check("R11", out_a, 64'h0);
        check("R11", {32'h0, rdata_a}, 64'h0);
        bus_read(9'h0C4); check("R11", {32'h0, rdata_a}, 64'h0101_0101);
        bus_read(9'h000); check("R11", {32'h0, rdata_a}, 64'h0);
        bus_read(9'h00C); check("R11", {32'h0, rdata_a}, 64'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule